// File: doc/BRIEF.md
# Destination Address Filter with Programmable Match Table

This block decides, frame by frame, whether an incoming frame should be kept, based only on its 48-bit destination address. The address arrives one byte per accepted cycle, first byte first. Once the sixth byte is in, the address is compared in parallel against a table of sixteen programmable station addresses. Each table entry can be switched in or out of the comparison on its own. The table result is then combined with per-class pass-through controls for unicast, multicast and broadcast frames.

Software programs the block through a simple word-addressed register port. This port holds a five-bit command word, an entry-enable mask and the sixteen address entries. The usual setup loads the station's own address into one entry, enables that entry, and sets table comparison together with broadcast and unicast pass-through. For each frame the block raises a one-cycle decision strobe. With the strobe it gives the keep/drop verdict, a flag saying whether an enabled entry matched, and the number of the matching entry.

Top module: `dst_addr_filter`

## Requirements
- R1: The command word is at byte offset 0x00 and uses bits 4:0: bit 0 passes every unicast frame, bit 1 passes every multicast frame, bit 2 passes broadcast frames, bit 3 inverts the table result, and bit 4 enables the table comparison. The entry-enable mask is at 0x04, with bit n enabling entry n. Unused bits read back as zero. After reset every register reads zero.
- R2: Entry n (n = 0..15) has a high word at 0x08+8n and a low word at 0x0C+8n. The high word holds address bytes 0..3, with byte 0 in bits 31:24. The low word holds byte 4 in bits 31:24 and byte 5 in bits 23:16, and its bits 15:0 read as zero. A write to any other offset, including an unaligned one, changes nothing, and a read of such an offset returns zero.
- R3: A byte taken with the start flag high begins a new address and abandons any partial one. Later bytes are taken only on cycles with the valid input high, so gaps are allowed. Bytes taken without a started address, and bytes after the sixth, are ignored.
- R4: The decision strobe is high for exactly one cycle. It rises two clock edges after the edge that takes the sixth byte.
- R5: With comparison enabled, an address equal to an enabled entry is kept. An entry whose enable bit is clear never matches.
- R6: The hit flag reports a match among the enabled entries, whatever the command word holds. The reported index is the lowest-numbered matching entry, and it is 0 when nothing matches.
- R7: With comparison enabled and the invert bit set, the table result is inverted, so a matching address is dropped and a non-matching one is kept.
- R8: A unicast address is one with bit 0 of byte 0 clear. With the unicast pass bit set, every unicast address is kept.
- R9: A multicast address is one with bit 0 of byte 0 set that is not all ones. With the multicast pass bit set, such an address is kept.
- R10: The all-ones address is broadcast. It is kept when the broadcast pass bit is set, and the multicast pass bit alone does not keep it.
- R11: With comparison disabled, only the three pass bits decide the verdict, even when an entry matches.
- R12: During and after reset the decision outputs are low until the first decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Byte offset of the write |
| reg_wr_data | input | 32 | Write data |
| reg_rd_addr | input | 8 | Byte offset of the read |
| reg_rd_data | output | 32 | Read data, combinational from reg_rd_addr |
| da_valid | input | 1 | Destination address byte present |
| da_first | input | 1 | This byte is byte 0 of a new address |
| da_byte | input | 8 | Destination address byte |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Keep (1) or drop (0) the frame |
| dec_hit | output | 1 | An enabled entry matched |
| dec_index | output | 4 | Lowest matching entry number |

## Verification
A corrupted register shows up right away on the read port, and it shows up in the verdict of the next frame that depends on it. A byte counter that slips makes the decision strobe early, late or missing relative to the sixth byte, and this is visible within two cycles. Bytes that are shifted or dropped turn into a wrong verdict or hit flag on that same strobe. A fault in the enable masking or the priority order shows up as a wrong entry number when several entries hold the same address, or as a hit on a disabled entry.

// File: rtl/daf_pkg.sv
package daf_pkg;
    localparam int MAC_BYTES = 6;
    localparam int MAC_W     = MAC_BYTES * 8;
    localparam int REG_W     = 32;
    localparam int LO_W      = MAC_W - REG_W;
    localparam int CMD_W     = 5;

    // Bit order matters: it is the software-visible command word layout.
    typedef struct packed {
        logic cmp_en;   // bit 4
        logic invert;   // bit 3
        logic pass_bc;  // bit 2
        logic pass_mc;  // bit 1
        logic pass_uc;  // bit 0
    } filt_cmd_t;
endpackage

// File: rtl/daf_regs.sv
module daf_regs
    import daf_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int RA_W    = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [RA_W-1:0]                  wr_addr,
    input  logic [REG_W-1:0]                 wr_data,
    input  logic [RA_W-1:0]                  rd_addr,
    output logic [REG_W-1:0]                 rd_data,
    output filt_cmd_t                        cmd,
    output logic [ENTRIES-1:0]               ent_en,
    output logic [ENTRIES-1:0][MAC_W-1:0]    ent_mac
);
    localparam int OFF_CMD  = 0;
    localparam int OFF_EN   = 4;
    localparam int OFF_TBL  = 8;
    localparam int STRIDE   = 8;

    typedef struct packed {
        filt_cmd_t                         cmd;
        logic [ENTRIES-1:0]                en;
        logic [ENTRIES-1:0][MAC_W-1:0]     mac;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_addr == RA_W'(OFF_CMD)) begin
                st_d.cmd = filt_cmd_t'(wr_data[CMD_W-1:0]);
            end
            if (wr_addr == RA_W'(OFF_EN)) begin
                st_d.en = wr_data[ENTRIES-1:0];
            end
            for (int i = 0; i < ENTRIES; i++) begin
                if (wr_addr == RA_W'(OFF_TBL + STRIDE * i)) begin
                    st_d.mac[i][MAC_W-1 -: REG_W] = wr_data;
                end
                if (wr_addr == RA_W'(OFF_TBL + STRIDE * i + 4)) begin
                    st_d.mac[i][LO_W-1:0] = wr_data[REG_W-1 -: LO_W];
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == RA_W'(OFF_CMD)) begin
            rd_data = {{(REG_W-CMD_W){1'b0}}, st_q.cmd};
        end
        if (rd_addr == RA_W'(OFF_EN)) begin
            rd_data = REG_W'(st_q.en);
        end
        for (int i = 0; i < ENTRIES; i++) begin
            if (rd_addr == RA_W'(OFF_TBL + STRIDE * i)) begin
                rd_data = st_q.mac[i][MAC_W-1 -: REG_W];
            end
            if (rd_addr == RA_W'(OFF_TBL + STRIDE * i + 4)) begin
                rd_data = {st_q.mac[i][LO_W-1:0], {(REG_W-LO_W){1'b0}}};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd     = st_q.cmd;
    assign ent_en  = st_q.en;
    assign ent_mac = st_q.mac;
endmodule

// File: rtl/daf_collect.sv
module daf_collect
    import daf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_first,
    input  logic [7:0]       in_byte,
    output logic [MAC_W-1:0] mac,
    output logic             done
);
    localparam int CNT_W = $clog2(MAC_BYTES + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [MAC_W-1:0] mac;
        logic             done;
    } col_t;

    col_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        if (in_valid) begin
            if (in_first) begin
                c_d.busy = 1'b1;
                c_d.cnt  = CNT_W'(1);
                c_d.mac  = {c_q.mac[MAC_W-9:0], in_byte};
            end else if (c_q.busy) begin
                c_d.mac = {c_q.mac[MAC_W-9:0], in_byte};
                c_d.cnt = c_q.cnt + CNT_W'(1);
                if (c_q.cnt == CNT_W'(MAC_BYTES - 1)) begin
                    c_d.busy = 1'b0;
                    c_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign mac  = c_q.mac;
    assign done = c_q.done;
endmodule

// File: rtl/daf_match.sv
module daf_match
    import daf_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [MAC_W-1:0]               mac,
    input  logic [ENTRIES-1:0]             ent_en,
    input  logic [ENTRIES-1:0][MAC_W-1:0]  ent_mac,
    output logic                           hit,
    output logic [IDX_W-1:0]               idx,
    output logic                           is_mc,
    output logic                           is_bc
);
    logic [ENTRIES-1:0] eq;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq[g] = ent_en[g] && (ent_mac[g] == mac);
    end

    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (eq[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    assign hit   = |eq;
    assign is_bc = &mac;
    assign is_mc = mac[MAC_W-8];   // group bit: bit 0 of byte 0
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
    import daf_pkg::*;
#(
    parameter int  ENTRIES = 16,
    parameter int  RA_W    = 8,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [RA_W-1:0]   reg_wr_addr,
    input  logic [REG_W-1:0]  reg_wr_data,
    input  logic [RA_W-1:0]   reg_rd_addr,
    output logic [REG_W-1:0]  reg_rd_data,
    input  logic              da_valid,
    input  logic              da_first,
    input  logic [7:0]        da_byte,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic              dec_hit,
    output logic [IDX_W-1:0]  dec_index
);
    typedef struct packed {
        logic             valid;
        logic             hit;
        logic [IDX_W-1:0] idx;
        logic             mc;
        logic             bc;
    } cmp_stage_t;

    typedef struct packed {
        logic             valid;
        logic             accept;
        logic             hit;
        logic [IDX_W-1:0] idx;
    } dec_stage_t;

    typedef struct packed {
        cmp_stage_t s1;
        dec_stage_t s2;
    } pipe_t;

    filt_cmd_t                       cmd;
    logic [ENTRIES-1:0]              ent_en;
    logic [ENTRIES-1:0][MAC_W-1:0]   ent_mac;
    logic [MAC_W-1:0]                addr;
    logic                            addr_done;
    logic                            m_hit;
    logic [IDX_W-1:0]                m_idx;
    logic                            m_mc;
    logic                            m_bc;

    pipe_t p_d, p_q;

    daf_regs #(.ENTRIES(ENTRIES), .RA_W(RA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_addr (reg_wr_addr),
        .wr_data (reg_wr_data),
        .rd_addr (reg_rd_addr),
        .rd_data (reg_rd_data),
        .cmd     (cmd),
        .ent_en  (ent_en),
        .ent_mac (ent_mac)
    );

    daf_collect u_collect (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (da_valid),
        .in_first (da_first),
        .in_byte  (da_byte),
        .mac      (addr),
        .done     (addr_done)
    );

    daf_match #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_match (
        .mac     (addr),
        .ent_en  (ent_en),
        .ent_mac (ent_mac),
        .hit     (m_hit),
        .idx     (m_idx),
        .is_mc   (m_mc),
        .is_bc   (m_bc)
    );

    always_comb begin
        logic tbl_ok;
        logic uc;
        logic mc_only;
        p_d = p_q;

        // stage 1: capture the parallel compare for a completed address
        p_d.s1.valid = addr_done;
        if (addr_done) begin
            p_d.s1.hit = m_hit;
            p_d.s1.idx = m_idx;
            p_d.s1.mc  = m_mc;
            p_d.s1.bc  = m_bc;
        end

        // stage 2: apply the command word
        tbl_ok  = cmd.cmp_en & (p_q.s1.hit ^ cmd.invert);
        uc      = ~p_q.s1.mc;
        mc_only = p_q.s1.mc & ~p_q.s1.bc;
        p_d.s2.valid = p_q.s1.valid;
        if (p_q.s1.valid) begin
            p_d.s2.accept = tbl_ok
                          | (uc & cmd.pass_uc)
                          | (mc_only & cmd.pass_mc)
                          | (p_q.s1.bc & cmd.pass_bc);
            p_d.s2.hit    = p_q.s1.hit;
            p_d.s2.idx    = p_q.s1.idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign dec_valid  = p_q.s2.valid;
    assign dec_accept = p_q.s2.accept;
    assign dec_hit    = p_q.s2.hit;
    assign dec_index  = p_q.s2.idx;
endmodule

// File: rtl/daf_chk.sv
module daf_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             addr_done,
    input logic             dec_valid,
    input logic             dec_accept,
    input logic             dec_hit,
    input logic [IDX_W-1:0] dec_index,
    input logic [4:0]       cmd_bits
);
    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_done |-> ##2 dec_valid);

    p_strobe_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(addr_done, 2));

    p_idx_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_hit) |-> (dec_index == '0));

    p_invert_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && $past(cmd_bits) == 5'b11000) |-> (dec_accept == !dec_hit));

    p_all_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && $past(cmd_bits[2:0]) == 3'b111) |-> dec_accept);

    p_closed_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && $past(cmd_bits) == 5'b00000) |-> !dec_accept);
endmodule

bind dst_addr_filter daf_chk #(.IDX_W(IDX_W)) u_daf_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_done  (addr_done),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept),
    .dec_hit    (dec_hit),
    .dec_index  (dec_index),
    .cmd_bits   (cmd)
);

// File: tb/dst_addr_filter_bench.sv
module dst_addr_filter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_wr_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic [7:0]  reg_rd_addr = '0;
    logic [31:0] reg_rd_data;
    logic        da_valid = 1'b0;
    logic        da_first = 1'b0;
    logic [7:0]  da_byte = '0;
    logic        dec_valid, dec_accept, dec_hit;
    logic [3:0]  dec_index;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    logic [4:0]  m_cmd = '0;
    logic [15:0] m_en = '0;
    logic [47:0] m_mac [16];

    localparam logic [47:0] STA   = 48'h02_11_22_33_44_55;
    localparam logic [47:0] OTHER = 48'h02_11_22_33_44_66;
    localparam logic [47:0] MCAST = 48'h01_00_5E_00_00_01;
    localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;
    localparam logic [47:0] BOGUS = 48'h0A_0B_0C_0D_0E_0F;

    dst_addr_filter u_dst_addr_filter (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .da_valid(da_valid), .da_first(da_first), .da_byte(da_byte),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_hit(dec_hit),
        .dec_index(dec_index)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<50000", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_rd_addr = a;
        #1;
        chk(req, reg_rd_data, exp);
    endtask

    task automatic set_cmd(input logic [4:0] v);
        wr(8'h00, {27'b0, v});
        m_cmd = v;
    endtask

    task automatic set_en(input logic [15:0] v);
        wr(8'h04, {16'b0, v});
        m_en = v;
    endtask

    task automatic set_entry(input int n, input logic [47:0] mac);
        wr(8'(8 + 8 * n), mac[47:16]);
        wr(8'(12 + 8 * n), {mac[15:0], 16'h0});
        m_mac[n] = mac;
    endtask

    // expectation taken from the requirements
    task automatic model(input logic [47:0] a, output logic acc, output logic hit,
                         output logic [3:0] idx);
        logic mc, bc;
        hit = 1'b0;
        idx = 4'd0;
        for (int i = 15; i >= 0; i--) begin
            if (m_en[i] && m_mac[i] == a) begin
                hit = 1'b1;
                idx = 4'(i);
            end
        end
        bc  = (a == BCAST);
        mc  = a[40] && !bc;
        acc = (m_cmd[4] && (hit ^ m_cmd[3])) || (!a[40] && m_cmd[0])
            || (mc && m_cmd[1]) || (bc && m_cmd[2]);
    endtask

    task automatic frame(input logic [47:0] a, input int gap, input string req);
        logic acc, hit;
        logic [3:0] idx;
        model(a, acc, hit, idx);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            da_valid = 1'b1; da_first = (i == 0); da_byte = a[47 - 8 * i -: 8];
            if (i < 5) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    da_valid = 1'b0; da_first = 1'b0; da_byte = 8'hA5;
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        da_valid = 1'b0; da_first = 1'b0;
        @(posedge clk); #1;
        chk({req, " R4 strobe not early"}, dec_valid, 0);
        @(posedge clk); #1;
        chk({req, " R4 strobe"}, dec_valid, 1);
        chk({req, " accept"}, dec_accept, acc);
        chk({req, " R6 hit"}, dec_hit, hit);
        chk({req, " R6 index"}, dec_index, idx);
        @(posedge clk); #1;
        chk({req, " R4 one-cycle strobe"}, dec_valid, 0);
    endtask

    task automatic count_strobes(input int cycles, output int seen);
        seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk); #1;
            if (dec_valid) seen++;
        end
    endtask

    task automatic t_reset();
        chk("R12 strobe after reset", dec_valid, 0);
        chk("R12 accept after reset", dec_accept, 0);
        chk("R12 hit after reset", dec_hit, 0);
        rd_chk(8'h00, 32'h0, "R1 command reset");
        rd_chk(8'h04, 32'h0, "R1 enable reset");
        rd_chk(8'h08, 32'h0, "R2 entry0 high reset");
    endtask

    task automatic t_regs();
        wr(8'h00, 32'hFFFF_FFFF);
        rd_chk(8'h00, 32'h0000_001F, "R1 command width");
        wr(8'h04, 32'hFFFF_FFFF);
        rd_chk(8'h04, 32'h0000_FFFF, "R1 enable width");
        wr(8'h20, 32'hDEAD_BEEF);
        wr(8'h24, 32'hCAFE_1234);
        rd_chk(8'h20, 32'hDEAD_BEEF, "R2 entry3 high");
        rd_chk(8'h24, 32'hCAFE_0000, "R2 entry3 low");
        wr(8'h84, 32'h1357_9BDF);
        rd_chk(8'h84, 32'h1357_0000, "R2 entry15 low");
        wr(8'h88, 32'hFFFF_FFFF);
        wr(8'hFC, 32'hFFFF_FFFF);
        wr(8'h09, 32'hFFFF_FFFF);
        rd_chk(8'h88, 32'h0, "R2 unmapped 0x88 reads zero");
        rd_chk(8'hFC, 32'h0, "R2 unmapped 0xFC reads zero");
        rd_chk(8'h08, 32'h0, "R2 unaligned write ignored");
        rd_chk(8'h84, 32'h1357_0000, "R2 entry15 untouched");
        rd_chk(8'h20, 32'hDEAD_BEEF, "R2 entry3 untouched");
        set_cmd(5'h00);
        set_en(16'h0);
        set_entry(3, 48'h0);
        set_entry(15, 48'h0);
    endtask

    task automatic t_station();
        set_entry(5, STA);
        set_en(16'h0020);
        set_cmd(5'h15);
        rd_chk(8'h30, 32'h0211_2233, "R2 station high word layout");
        rd_chk(8'h34, 32'h4455_0000, "R2 station low word layout");
        frame(STA, 0, "R5 station frame");
        frame(BCAST, 0, "R10 broadcast in typical setup");
        frame(MCAST, 0, "R9 multicast dropped in typical setup");
        frame(OTHER, 0, "R8 foreign unicast passed");
    endtask

    task automatic t_match();
        set_cmd(5'h10);
        set_entry(2, STA);
        set_entry(9, STA);
        set_en(16'h0204);
        frame(STA, 0, "R6 lowest of two matches");
        set_en(16'h0200);
        frame(STA, 0, "R6 higher entry alone");
        set_en(16'h0000);
        frame(STA, 0, "R5 disabled entries never match");
        set_entry(15, OTHER);
        set_en(16'hFFFF);
        frame(OTHER, 0, "R6 last entry");
        frame(48'h02_99_99_99_99_99, 0, "R5 no match dropped");
    endtask

    task automatic t_invert();
        set_cmd(5'h18);
        frame(STA, 0, "R7 inverted match dropped");
        frame(48'h02_99_99_99_99_99, 0, "R7 inverted miss kept");
    endtask

    task automatic t_classes();
        set_en(16'h0020);
        set_cmd(5'h00);
        frame(STA, 0, "R11 match ignored with compare off");
        set_cmd(5'h01);
        frame(OTHER, 0, "R8 unicast pass");
        frame(MCAST, 0, "R8 unicast pass leaves multicast");
        set_cmd(5'h02);
        frame(MCAST, 0, "R9 multicast pass");
        frame(BCAST, 0, "R10 multicast pass leaves broadcast");
        frame(OTHER, 0, "R9 multicast pass leaves unicast");
        set_cmd(5'h04);
        frame(BCAST, 0, "R10 broadcast pass");
        frame(MCAST, 0, "R10 broadcast pass leaves multicast");
        set_cmd(5'h07);
        frame(BCAST, 0, "R11 all pass bits");
    endtask

    task automatic t_stream();
        int seen;
        set_cmd(5'h10);
        set_en(16'h0020);
        frame(STA, 2, "R3 gaps between bytes");
        // bytes without a start flag
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            da_valid = 1'b1; da_first = 1'b0; da_byte = STA[47 - 8 * i -: 8];
        end
        @(negedge clk);
        da_valid = 1'b0;
        count_strobes(8, seen);
        chk("R3 unstarted bytes ignored", seen, 0);
        // partial address abandoned by a new start
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            da_valid = 1'b1; da_first = (i == 0); da_byte = BOGUS[47 - 8 * i -: 8];
        end
        frame(STA, 0, "R3 restart mid address");
        // trailing bytes after the sixth
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            da_valid = 1'b1; da_first = 1'b0; da_byte = 8'h55;
        end
        @(negedge clk);
        da_valid = 1'b0;
        count_strobes(8, seen);
        chk("R3 bytes after sixth ignored", seen, 0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) m_mac[i] = '0;
        repeat (4) @(negedge clk);
        #1;
        chk("R12 strobe held in reset", dec_valid, 0);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_station();
        t_match();
        t_invert();
        t_classes();
        t_stream();
        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule